// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block merges a bank of level-sensitive interrupt request lines into a single interrupt output for a processor. Each request line is first synchronised into the clock domain. Its current level is then kept in a line-state register. A pending register accumulates every line that has been seen high and holds each bit until software acknowledges it. A mask register, written by software, decides which pending bits can drive the output. The output is a registered OR over the unmasked pending bits.

Software reaches the registers through a small synchronous port. The port has a write enable, a two-bit register select, write data and registered read data. A write to the pending register is an acknowledge: it clears only the bits that are 1 in the written value. The pending register is refreshed from the live line-state every cycle, so a line that is still high cannot be acknowledged away. For debug statistics, each line also has a saturating counter of its rising edges. The counters are read through a separate index port.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, mask, pending, line-state, every counter and `irq_out` are zero.
- R2: A line-state bit becomes 1 two clocks after its input is sampled high (two-flop synchroniser), and becomes 0 the same way after the input goes low.
- R3: A pending bit is set whenever its line-state bit is 1 and stays set after the line drops, until it is acknowledged.
- R4: `irq_out` is registered. It equals the OR of (pending AND mask) as held one clock earlier, so it changes one clock after a change in pending or mask.
- R5: A write with `reg_sel`=1 (pending) clears each pending bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R6: A pending bit whose line-state bit is 1 in the acknowledge cycle stays set; the live line wins over the acknowledge.
- R7: A write with `reg_sel`=0 replaces the whole mask, and the read value of the mask equals the last written value.
- R8: A write with `reg_sel`=2 (line-state) has no effect on any register.
- R9: A line's counter increments by exactly one for each rising edge of its synchronised level. It does not change while the line stays high.
- R10: A counter that reaches its all-ones value stays there instead of wrapping.
- R11: `reg_rdata` is registered and shows, one clock after `reg_sel` is applied, the mask (sel 0), the pending register (sel 1) or the line-state (sel 2). Sel 3 reads zero.
- R12: `cnt_rdata` shows, one clock after `cnt_idx` is applied, the counter of the line selected by `cnt_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous level interrupt requests |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 mask, 1 pending, 2 line-state, 3 unused |
| reg_wdata | input | N_LINES | Write data (mask value or acknowledge pattern) |
| reg_rdata | output | N_LINES | Registered read data of the selected register |
| cnt_idx | input | IDX_W | Line index for the counter read port |
| cnt_rdata | output | CNT_W | Registered counter value of the indexed line |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The acknowledge and the re-latch from the live line-state both write the pending register in the same cycle. The bench provokes this by holding a line high and writing a 1 to that line's pending bit. The pending bit must survive the acknowledge. The bench then lowers the line, waits for the synchroniser to settle, repeats the acknowledge and expects the bit to be gone. A mask write and a pending change racing to the output are judged by sampling `irq_out` both in the clock before the mask change takes effect and in the clock after.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_LINE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_counter_bank.sv
module irq_counter_bank #(
  parameter int N_LINES = 32,
  parameter int CNT_W   = 32,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] rise,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]   rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else if (rise[g] && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    // R10: a counter never moves backwards outside reset (no wrap)
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (cnt_q[g] >= $past(cnt_q[g])));

    // R9: without a rising edge the counter holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rise[g])) |-> $stable(cnt_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (int'(rd_idx) < N_LINES) ? cnt_q[rd_idx] : '0;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggregator_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  input  logic [IDX_W-1:0]   cnt_idx,
  output logic [CNT_W-1:0]   cnt_rdata,
  output logic               irq_out
);
  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] line_d1_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] ack_vec;
  logic [N_LINES-1:0] rise;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(reg_sel);

  irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (line_q)
  );

  assign ack_vec = (reg_we && sel == SEL_PEND) ? reg_wdata : '0;
  assign rise    = line_q & ~line_d1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d1_q <= '0;
      mask_q    <= '0;
      pend_q    <= '0;
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      line_d1_q <= line_q;
      if (reg_we && sel == SEL_MASK) mask_q <= reg_wdata;
      pend_q    <= (pend_q & ~ack_vec) | line_q;
      irq_out   <= |(pend_q & mask_q);
      unique case (sel)
        SEL_MASK: reg_rdata <= mask_q;
        SEL_PEND: reg_rdata <= pend_q;
        SEL_LINE: reg_rdata <= line_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  irq_counter_bank #(.N_LINES(N_LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .rd_idx  (cnt_idx),
    .rd_data (cnt_rdata)
  );

  // R7: a mask write is visible in the next cycle
  p_mask_write_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd0) |=> (mask_q == $past(reg_wdata)));

  // R3: without an acknowledge no pending bit is lost
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_sel == 2'd1) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6: a live line is always pending one cycle later
  p_live_pending_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q & $past(line_q)) == $past(line_q)));

  // R4: an all-zero mask keeps the output low in the following cycle
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int N  = 32;
  localparam int CW = 4;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic [IW-1:0] cnt_idx = '0;
  logic [CW-1:0] cnt_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator #(.N_LINES(N), .CNT_W(CW), .SYNC_STAGES(2), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_idx(cnt_idx),
    .cnt_rdata(cnt_rdata), .irq_out(irq_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [N-1:0] v);
    reg_sel = s;
    step(1);
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] v);
    reg_sel = s; reg_wdata = v; reg_we = 1'b1;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_cnt(input int idx, output logic [CW-1:0] v);
    cnt_idx = IW'(idx);
    step(1);
    v = cnt_rdata;
  endtask

  task automatic pulse(input int line, input int times);
    for (int i = 0; i < times; i++) begin
      irq_in[line] = 1'b1; step(3);
      irq_in[line] = 1'b0; step(3);
    end
    step(4);
  endtask

  task automatic t_reset;
    logic [N-1:0] v; logic [CW-1:0] c;
    check("R1 irq_out", 32'(irq_out), 0);
    rd(2'd0, v); check("R1 mask", v, 0);
    rd(2'd1, v); check("R1 pending", v, 0);
    rd(2'd2, v); check("R1 line", v, 0);
    rd_cnt(0, c);  check("R1 cnt0", 32'(c), 0);
    rd_cnt(31, c); check("R1 cnt31", 32'(c), 0);
  endtask

  task automatic t_line_sticky;
    logic [N-1:0] v;
    irq_in = 32'h0000_00A0; step(4);
    rd(2'd2, v); check("R2 line high", v, 32'h0000_00A0);
    rd(2'd1, v); check("R3 pending set", v, 32'h0000_00A0);
    irq_in = '0; step(4);
    rd(2'd2, v); check("R2 line low", v, 0);
    rd(2'd1, v); check("R3 pending sticky", v, 32'h0000_00A0);
    wr(2'd1, '1);
    rd(2'd1, v); check("R5 ack all", v, 0);
  endtask

  task automatic t_ack_partial;
    logic [N-1:0] v;
    irq_in = 32'h7; step(4);
    irq_in = '0; step(4);
    wr(2'd1, 32'h5);
    rd(2'd1, v); check("R5 partial ack", v, 32'h2);
  endtask

  task automatic t_mask_out;
    logic [N-1:0] v;
    check("R4 masked low", 32'(irq_out), 0);
    wr(2'd0, 32'h2);
    check("R4 latency", 32'(irq_out), 0);
    step(1);
    check("R4 unmasked high", 32'(irq_out), 1);
    rd(2'd0, v); check("R7 mask read", v, 32'h2);
    wr(2'd0, 32'h1);
    step(1);
    check("R7 mask replaced", 32'(irq_out), 0);
    rd(2'd0, v); check("R11 mask sel0", v, 32'h1);
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_ack_live;
    logic [N-1:0] v;
    irq_in = 32'h8; step(4);
    wr(2'd1, 32'h8);
    rd(2'd1, v); check("R6 live survives ack", v, 32'h8);
    irq_in = '0; step(4);
    wr(2'd1, 32'h8);
    rd(2'd1, v); check("R6 ack after drop", v, 0);
  endtask

  task automatic t_line_ro;
    logic [N-1:0] v;
    irq_in = 32'h10; step(4);
    wr(2'd2, '1);
    rd(2'd2, v); check("R8 line unchanged", v, 32'h10);
    rd(2'd0, v); check("R8 mask unchanged", v, 0);
    rd(2'd1, v); check("R8 pending unchanged", v, 32'h10);
    rd(2'd3, v); check("R11 sel3 zero", v, 0);
    irq_in = '0; step(4);
    wr(2'd1, '1);
  endtask

  task automatic t_counters;
    logic [CW-1:0] c;
    rd_cnt(7, c); check("R9 one rise", 32'(c), 1);
    rd_cnt(3, c); check("R9 held high once", 32'(c), 1);
    rd_cnt(1, c); check("R12 index 1", 32'(c), 1);
    pulse(9, 3);
    rd_cnt(9, c); check("R9 three rises", 32'(c), 3);
    rd_cnt(8, c); check("R12 neighbour", 32'(c), 0);
    pulse(10, 20);
    rd_cnt(10, c); check("R10 saturate", 32'(c), 15);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    t_reset();
    t_line_sticky();
    t_ack_partial();
    t_mask_out();
    t_ack_live();
    t_line_ro();
    t_counters();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule